// File: doc/BRIEF.md
# Cartridge-Port to ISA I/O Bridge

This block lets a host whose expansion connector only supports read cycles talk to an ISA-style I/O target, such as a network controller. When the host's select is active and its address falls in one of two windows, the bridge runs one ISA I/O cycle. Address bit 16 chooses the kind of cycle. With the bit clear, the access is an ISA read. With the bit set, the access is an ISA write, and the data byte for that write is taken from the host address itself. Five host address bits pick the target register, and the rest of the ISA address is fixed at a parameterised I/O base.

In byte mode, read data comes back in the upper half of the host word. In word mode, reads return the whole 16-bit target word. A word write takes two host cycles. First, a read-window access stores its address byte as the pending low byte. Then a write-window access supplies the high byte and fires one 16-bit write. Each ISA strobe lasts a parameterised number of clocks. The host data bus is enabled only for cycles that hit a window, and it stays enabled until the host releases the select.

Top module: `cart_isa_bridge`

## Requirements
- R1: During a strobe, `isa_addr` equals the upper bits of `ISA_BASE` (base 0x300 by default) with host address bits 13..9 in its low five bits. The address stays stable for the whole strobe.
- R2: When the select is sampled active in idle with a window hit, the strobe starts on the next clock. Address bit 16 = 0 asserts `isa_ior_n` and address bit 16 = 1 asserts `isa_iow_n`. The strobe lasts exactly `STROBE_CLKS` clocks, and the two strobes are never low together.
- R3: A byte-mode read (`mode16`=0) returns target data bits 7..0 on `host_dout` bits 15..8, with bits 7..0 zero. The value is sampled on the clock that ends the strobe.
- R4: In a byte-mode write, `isa_dout` = {8'h00, host address bits 8..1}. `isa_doe` is high for exactly the clocks that `isa_iow_n` is low.
- R5: A word-mode read (`mode16`=1) returns the full 16-bit target word on `host_dout`.
- R6: A word-mode read-window access stores host address bits 8..1 as the pending low byte. A following word-mode write-window access drives `isa_dout` = {address bits 8..1, pending low byte}.
- R7: The pending low byte is cleared to zero after every word write.
- R8: A word write with no pending low byte uses a zero low byte and sets `err_sticky`. `err_sticky` stays set until reset.
- R9: Byte-mode accesses leave the pending low byte untouched.
- R10: `host_oe` rises on the clock after the select is sampled active for a window hit. It falls on the clock after the select is sampled inactive. On write-window cycles `host_dout` is zero.
- R11: A select with address bits 23..17 not equal to `WIN_TAG` starts no strobe, never raises `host_oe`, and leaves the pending low byte unchanged.
- R12: A select held active for any length of time produces one ISA cycle. A new cycle can start only after the select is released. A select released during the strobe still completes the full strobe.
- R13: While reset is asserted and just after it, both strobes are high, `host_oe` and `isa_doe` are low, and `err_sticky` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host cartridge select, active high |
| host_addr | input | ADDR_W | Host address; bit 16 chooses write window, 13..9 register, 8..1 data byte |
| mode16 | input | 1 | 1 = word-wide target, 0 = byte-wide target |
| host_dout | output | 16 | Data returned to the host |
| host_oe | output | 1 | Host data bus enable (bus released when low) |
| isa_addr | output | ISA_AW | ISA I/O address |
| isa_ior_n | output | 1 | ISA read strobe, active low |
| isa_iow_n | output | 1 | ISA write strobe, active low |
| isa_din | input | 16 | Data from the ISA target |
| isa_dout | output | 16 | Data to the ISA target |
| isa_doe | output | 1 | ISA data drive enable |
| err_sticky | output | 1 | Set by a word write without a pending low byte |

## Verification
The bench builds the bridge with `STROBE_CLKS` = 2 and leaves the window tag, the base and the widths at their defaults. The short strobe means a select held for a single clock is released while the strobe is still running, which exercises the R12 rule that the strobe runs to completion. A twelve-clock select exercises the other side of R12, that a long select still gives only one cycle. Alternating the mode between cycles exercises the pending low byte across byte-mode reads, orphan word writes and repeated latches.

// File: rtl/cib_pkg.sv
package cib_pkg;
  localparam int BYTE_W  = 8;
  localparam int IDX_W   = 5;
  localparam int WR_BIT  = 16;
  localparam int IDX_LSB = 9;
  localparam int DAT_LSB = 1;
  localparam int WIN_LSB = 17;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STROBE,
    ST_HOLD,
    ST_SKIP
  } cib_state_t;

  typedef struct packed {
    logic              hit;
    logic              is_wr;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] dbyte;
  } cib_req_t;
endpackage

// File: rtl/cib_decode.sv
module cib_decode
  import cib_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-WIN_LSB-1:0] WIN_TAG = 7'h7D
) (
  input  logic [ADDR_W-1:0] addr,
  output cib_req_t          req
);
  always_comb begin
    req.hit   = (addr[ADDR_W-1:WIN_LSB] == WIN_TAG);
    req.is_wr = addr[WR_BIT];
    req.idx   = addr[IDX_LSB +: IDX_W];
    req.dbyte = addr[DAT_LSB +: BYTE_W];
  end
endmodule

// File: rtl/cib_lowbyte.sv
module cib_lowbyte
  import cib_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              latch,
  input  logic              commit,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BYTE_W-1:0] held_byte,
  output logic              held_vld,
  output logic              err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_byte <= '0;
      held_vld  <= 1'b0;
      err       <= 1'b0;
    end else if (commit) begin
      held_byte <= '0;
      held_vld  <= 1'b0;
      if (!held_vld) err <= 1'b1;
    end else if (latch) begin
      held_byte <= byte_in;
      held_vld  <= 1'b1;
    end
  end

  // R7
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (!held_vld && held_byte == '0));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/cib_seq.sv
module cib_seq
  import cib_pkg::*;
#(
  parameter int   STROBE_CLKS = 3,
  parameter int   ISA_AW      = 10,
  parameter logic [ISA_AW-1:0] ISA_BASE = 10'h300,
  parameter int   DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              mode16,
  input  cib_req_t          req,
  input  logic [BYTE_W-1:0] held_byte,
  input  logic [DATA_W-1:0] isa_din,
  output logic              latch,
  output logic              commit,
  output logic [ISA_AW-1:0] isa_addr,
  output logic              ior_n,
  output logic              iow_n,
  output logic [DATA_W-1:0] isa_dout,
  output logic              isa_doe,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_oe
);
  localparam int CNT_W = $clog2(STROBE_CLKS + 1);
  localparam int HI_W  = ISA_AW - IDX_W;
  localparam logic [HI_W-1:0] BASE_HI = ISA_BASE[ISA_AW-1:IDX_W];

  cib_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             cur_wr;
  logic             cur_m16;
  logic             start;

  assign start  = (state == ST_IDLE) && sel && req.hit;
  assign latch  = start && mode16 && !req.is_wr;
  assign commit = start && mode16 && req.is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      cur_wr    <= 1'b0;
      cur_m16   <= 1'b0;
      ior_n     <= 1'b1;
      iow_n     <= 1'b1;
      isa_addr  <= {BASE_HI, {IDX_W{1'b0}}};
      isa_dout  <= '0;
      isa_doe   <= 1'b0;
      host_dout <= '0;
      host_oe   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sel) begin
            if (req.hit) begin
              state     <= ST_STROBE;
              cnt       <= CNT_W'(STROBE_CLKS - 1);
              cur_wr    <= req.is_wr;
              cur_m16   <= mode16;
              isa_addr  <= {BASE_HI, req.idx};
              ior_n     <= req.is_wr;
              iow_n     <= !req.is_wr;
              host_oe   <= 1'b1;
              host_dout <= '0;
              if (req.is_wr) begin
                isa_doe  <= 1'b1;
                isa_dout <= mode16 ? {req.dbyte, held_byte}
                                   : {{(DATA_W-BYTE_W){1'b0}}, req.dbyte};
              end
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            ior_n   <= 1'b1;
            iow_n   <= 1'b1;
            isa_doe <= 1'b0;
            state   <= ST_HOLD;
            if (!cur_wr)
              host_dout <= cur_m16 ? isa_din
                                   : {isa_din[BYTE_W-1:0], {(DATA_W-BYTE_W){1'b0}}};
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (!sel) begin
            state   <= ST_IDLE;
            host_oe <= 1'b0;
          end
        end
      endcase
    end
  end

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (ior_n || iow_n));

  // R4
  wdata_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !iow_n |-> isa_doe);

  // R1
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!ior_n && $past(!ior_n)) |-> $stable(isa_addr));

  // R10
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(host_oe) |-> !$past(sel));
endmodule

// File: rtl/cart_isa_bridge.sv
module cart_isa_bridge
  import cib_pkg::*;
#(
  parameter int   ADDR_W      = 24,
  parameter logic [ADDR_W-WIN_LSB-1:0] WIN_TAG = 7'h7D,
  parameter int   ISA_AW      = 10,
  parameter logic [ISA_AW-1:0] ISA_BASE = 10'h300,
  parameter int   STROBE_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              mode16,
  output logic [15:0]       host_dout,
  output logic              host_oe,
  output logic [ISA_AW-1:0] isa_addr,
  output logic              isa_ior_n,
  output logic              isa_iow_n,
  input  logic [15:0]       isa_din,
  output logic [15:0]       isa_dout,
  output logic              isa_doe,
  output logic              err_sticky
);
  cib_req_t          req;
  logic              latch;
  logic              commit;
  logic [BYTE_W-1:0] held_byte;
  logic              held_vld;

  cib_decode #(.ADDR_W(ADDR_W), .WIN_TAG(WIN_TAG)) u_dec (
    .addr (host_addr),
    .req  (req)
  );

  cib_lowbyte u_low (
    .clk       (clk),
    .rst       (rst),
    .latch     (latch),
    .commit    (commit),
    .byte_in   (req.dbyte),
    .held_byte (held_byte),
    .held_vld  (held_vld),
    .err       (err_sticky)
  );

  cib_seq #(
    .STROBE_CLKS (STROBE_CLKS),
    .ISA_AW      (ISA_AW),
    .ISA_BASE    (ISA_BASE),
    .DATA_W      (16)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .sel       (host_sel),
    .mode16    (mode16),
    .req       (req),
    .held_byte (held_byte),
    .isa_din   (isa_din),
    .latch     (latch),
    .commit    (commit),
    .isa_addr  (isa_addr),
    .ior_n     (isa_ior_n),
    .iow_n     (isa_iow_n),
    .isa_dout  (isa_dout),
    .isa_doe   (isa_doe),
    .host_dout (host_dout),
    .host_oe   (host_oe)
  );
endmodule

// File: tb/cart_isa_bridge_test.sv
`timescale 1ns/1ps
module cart_isa_bridge_test;
  localparam int STB = 2;
  localparam logic [6:0] TAG = 7'h7D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_sel = 1'b0;
  logic [23:0] host_addr = '0;
  logic        mode16 = 1'b0;
  logic [15:0] host_dout;
  logic        host_oe;
  logic [9:0]  isa_addr;
  logic        isa_ior_n, isa_iow_n;
  logic [15:0] isa_din;
  logic [15:0] isa_dout;
  logic        isa_doe;
  logic        err_sticky;

  always #10 clk = ~clk;

  function automatic logic [15:0] tgt(input logic [9:0] a);
    return {a[7:0] ^ 8'hC3, a[7:0] + 8'h2B};
  endfunction
  assign isa_din = tgt(isa_addr);

  cart_isa_bridge #(.STROBE_CLKS(STB)) uut (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_addr(host_addr),
    .mode16(mode16), .host_dout(host_dout), .host_oe(host_oe),
    .isa_addr(isa_addr), .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n),
    .isa_din(isa_din), .isa_dout(isa_dout), .isa_doe(isa_doe),
    .err_sticky(err_sticky)
  );

  int compared = 0;
  int mismatched = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int         m_phase = 0;
  int         m_left = 0;
  bit         m_wr = 0, m_m16 = 0, started = 0;
  logic [7:0] m_hold = 0;
  bit         m_hvld = 0;
  logic       e_ior = 1, e_iow = 1, e_doe = 0, e_oe = 0, e_err = 0;
  logic [9:0] e_addr = 10'h300;
  logic [15:0] e_dout = 0, e_host = 0;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_phase = 0; m_hold = 0; m_hvld = 0;
      e_ior = 1; e_iow = 1; e_doe = 0; e_oe = 0; e_err = 0;
      e_addr = 10'h300; e_dout = 0; e_host = 0;
    end else if (m_phase == 0) begin
      if (host_sel && host_addr[23:17] == TAG) begin
        m_wr = host_addr[16]; m_m16 = mode16; m_phase = 1; m_left = STB;
        e_addr = 10'h300 + 10'(host_addr[13:9]);
        e_ior = m_wr; e_iow = !m_wr; e_oe = 1; e_host = 0;
        if (m_wr) begin
          e_doe = 1;
          if (m_m16) begin
            e_dout = {host_addr[8:1], m_hold};
            if (!m_hvld) e_err = 1;
            m_hold = 0; m_hvld = 0;
          end else e_dout = {8'h00, host_addr[8:1]};
        end else if (m_m16) begin
          m_hold = host_addr[8:1]; m_hvld = 1;
        end
      end else if (host_sel) m_phase = 3;
    end else if (m_phase == 1) begin
      m_left = m_left - 1;
      if (m_left == 0) begin
        e_ior = 1; e_iow = 1; e_doe = 0; m_phase = 2;
        if (!m_wr) e_host = m_m16 ? tgt(e_addr) : {tgt(e_addr) & 16'h00FF} << 8;
      end
    end else if (!host_sel) begin
      m_phase = 0; e_oe = 0;
    end
  end

  // observation
  int   strobes = 0;
  bit   seen_oe = 0;
  logic p_ior = 1, p_iow = 1;
  logic [15:0] last_word = 0;

  always @(negedge clk) begin
    if (started) begin
      chk("R2 ior_n", isa_ior_n, e_ior);
      chk("R2 iow_n", isa_iow_n, e_iow);
      chk("R1 isa_addr", isa_addr, e_addr);
      chk("R4 isa_doe", isa_doe, e_doe);
      if (e_doe) chk(m_m16 ? "R6 isa_dout" : "R4 isa_dout", isa_dout, e_dout);
      chk("R10 host_oe", host_oe, e_oe);
      if (e_oe) chk(m_wr ? "R10 host_dout" : (m_m16 ? "R5 host_dout" : "R3 host_dout"),
                    host_dout, e_host);
      chk("R8 err_sticky", err_sticky, e_err);
      if ((p_ior && !isa_ior_n) || (p_iow && !isa_iow_n)) strobes++;
      if (host_oe) seen_oe = 1;
      if (!isa_iow_n) last_word = isa_dout;
      p_ior = isa_ior_n; p_iow = isa_iow_n;
    end
  end

  task automatic cyc(input bit wr, input bit m16, input logic [4:0] idx,
                     input logic [7:0] b, input int hold, input logic [6:0] tag = TAG);
    @(negedge clk); #1;
    host_addr = {tag, wr, 2'b00, idx, b, 1'b0};
    mode16 = m16;
    host_sel = 1;
    repeat (hold) @(negedge clk);
    #1 host_sel = 0;
    repeat (STB + 2) @(negedge clk);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      mismatched++; compared++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 ior_n", isa_ior_n, 1);
    chk("R13 iow_n", isa_iow_n, 1);
    chk("R13 host_oe", host_oe, 0);
    chk("R13 err", err_sticky, 0);
    #1 rst = 0;
    repeat (2) @(negedge clk);

    // byte reads and writes
    cyc(0, 0, 5'd0, 8'h00, STB + 3);
    cyc(0, 0, 5'd5, 8'hFF, STB + 3);
    cyc(0, 0, 5'd31, 8'h81, STB + 3);
    cyc(1, 0, 5'd7, 8'hA5, STB + 3);
    cyc(1, 0, 5'd16, 8'h3C, STB + 3);

    // R9: byte accesses between latch and word write
    cyc(0, 1, 5'd2, 8'h34, STB + 3);
    cyc(0, 0, 5'd9, 8'h77, STB + 3);
    cyc(1, 0, 5'd9, 8'h66, STB + 3);
    cyc(1, 1, 5'd2, 8'h12, STB + 3);
    chk("R9 word kept low byte", last_word, 16'h1234);
    chk("R8 no error yet", err_sticky, 0);

    // R7/R8: orphan word write
    cyc(1, 1, 5'd2, 8'h56, STB + 3);
    chk("R7 low byte cleared", last_word, 16'h5600);
    chk("R8 error set", err_sticky, 1);

    // R11: out-of-window select
    strobes = 0; seen_oe = 0;
    cyc(0, 1, 5'd3, 8'hEE, STB + 3, 7'h10);
    cyc(1, 1, 5'd3, 8'hEE, STB + 3, 7'h10);
    chk("R11 no strobe", strobes, 0);
    chk("R11 no drive", seen_oe, 0);
    cyc(1, 1, 5'd4, 8'h9A, STB + 3);
    chk("R11 low byte unchanged", last_word, 16'h9A00);

    // R12: long and short selects
    strobes = 0;
    cyc(0, 0, 5'd12, 8'h01, 12);
    chk("R12 one cycle long select", strobes, 1);
    strobes = 0;
    cyc(0, 1, 5'd13, 8'hC8, 1);
    chk("R12 short select full strobe", strobes, 1);
    cyc(0, 0, 5'd14, 8'h02, STB + 3);
    cyc(1, 1, 5'd13, 8'hB7, STB + 3);
    chk("R6 word assembled", last_word, 16'hB7C8);
    cyc(0, 1, 5'd20, 8'h00, STB + 3);
    chk("R8 still set", err_sticky, 1);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule